// File: doc/BRIEF.md
# FPGA Configuration Control Sequencer

This block is the control and status side of a loader that pushes a configuration image into an FPGA fabric. Software reaches it through a small 32-bit register port with a status word and a control word. Configuration words arrive on a separate write port. The block drives the fabric's configuration-reset pull and chip-enable. It moves a 3-bit phase code through power-up, reset, configuration, initialization and user mode.

In the configuration phase, each accepted data word is serialized onto a configuration data bus. It goes out as one 32-bit beat, or as two 16-bit beats with the low half first. Each beat is held for 1, 2, 4 or 8 configuration clock strobes. When the fabric raises both its done and status lines, the block clears the transfer enable itself. It then issues four more configuration clocks before it reports user mode. Clearing the master enable stops all activity but keeps the reported phase.

Top module: `cfg_sequencer`

## Requirements
- R1: After synchronous reset the phase is 0 (power-up), the control word reads 0x2 (chip enable deasserted), the error flag is low and no strobe is issued.
- R2: A register read returns its value one cycle after the address is presented. Offset 0x0 returns the phase in bits [2:0] and the 5 mode-select pins in bits [7:3]. Offset 0x4 returns the control word, in which only bits 0, 1, 2 and 6 to 9 are writable. Chip-enable output `cfg_ce_n` follows control bit 1.
- R3: With enable (control bit 0) set, setting the reset-pull bit (bit 2) moves the phase to 1 (reset). Clearing the pull then moves it to 2 (configuration). `cfg_pull` is high only while both enable and pull are set.
- R4: A data write is taken only in phase 2 with transfer enable (control bit 8) set. With transfer enable clear, a write in phase 2 produces no strobe and no error.
- R5: With width bit 9 set, a word is sent as one beat of N strobes, where N = 2^ratio and ratio is control bits [7:6]. The first strobe appears one cycle after the write is taken.
- R6: With width bit 9 clear, a word is sent as two beats of N strobes each. The low 16 bits go first, then the high 16 bits, both zero-extended on `cfg_data`.
- R7: A data write outside phase 2, or while a word is still being sent, is dropped and sets `data_err`. The flag stays set until reset.
- R8: In phase 2, with no word in flight and both done and status inputs high, the phase moves to 3 and control bit 8 clears. Four strobes with zero data follow, then the phase becomes 4 (user mode).
- R9: In phase 2 with enable set, done and status inputs both low move the phase to 5 (unknown).
- R10: While enable is clear, the phase does not change whatever the other inputs do, and any word in flight stops with no further strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data for `reg_addr` |
| data_wr | input | 1 | Configuration data write strobe |
| data_in | input | DATA_W | Configuration data word |
| mode_pins | input | MODE_W | Mode-select pin levels |
| done_in | input | 1 | Fabric done line |
| stat_in | input | 1 | Fabric status line (high means good) |
| cfg_pull | output | 1 | Configuration-reset pull to the fabric |
| cfg_ce_n | output | 1 | Active-low chip enable to the fabric |
| cfg_strobe | output | 1 | One configuration clock per high cycle |
| cfg_data | output | DATA_W | Beat data presented with each strobe |
| data_err | output | 1 | Sticky dropped-write flag |

## Verification
The register read path has one cycle of latency. A phase change lands one edge after the control write that causes it, so the bench waits two idle cycles after each control write and then reads the phase. The beat stream starts at the edge after the accepting edge, so the bench samples `cfg_strobe` and `cfg_data` at every falling edge for exactly N or 2N cycles and then expects one quiet cycle. The finishing clocks follow the same count from the edge that enters phase 3, and the error flag is checked at the first falling edge after the offending write.

// File: rtl/cfgseq_pkg.sv
package cfgseq_pkg;
  localparam int unsigned REG_W   = 32;
  localparam int unsigned PHASE_W = 3;

  typedef enum logic [PHASE_W-1:0] {
    PH_PWRUP = 3'd0,
    PH_RST   = 3'd1,
    PH_CFG   = 3'd2,
    PH_INIT  = 3'd3,
    PH_USER  = 3'd4,
    PH_UNK   = 3'd5
  } phase_e;

  // control word bit positions
  localparam int unsigned CB_EN    = 0;
  localparam int unsigned CB_NCE   = 1;
  localparam int unsigned CB_PULL  = 2;
  localparam int unsigned CB_RATIO = 6;
  localparam int unsigned CB_XFER  = 8;
  localparam int unsigned CB_WIDTH = 9;

  localparam logic [REG_W-1:0] CTRL_MASK  = 32'h0000_03C7;
  localparam logic [REG_W-1:0] CTRL_RESET = 32'h0000_0002;

  localparam int unsigned OFS_STATUS = 0;
  localparam int unsigned OFS_CTRL   = 4;
endpackage

// File: rtl/cfgseq_beat.sv
module cfgseq_beat
  import cfgseq_pkg::*;
#(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned RATIO_W = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               en,
  input  logic               in_cfg,
  input  logic               xfer,
  input  logic               wr,
  input  logic [DATA_W-1:0]  wdata,
  input  logic               width32,
  input  logic [RATIO_W-1:0] ratio,
  output logic               strobe,
  output logic [DATA_W-1:0]  dat,
  output logic               busy,
  output logic               err
);
  localparam int unsigned HALF_W = DATA_W / 2;
  localparam int unsigned SUB_W  = (1 << RATIO_W) - 1;

  logic [DATA_W-1:0]  word_q;
  logic               w32_q;
  logic [RATIO_W-1:0] ratio_q;
  logic [SUB_W-1:0]   sub_q;
  logic               hi_q;
  logic [SUB_W:0]     span;
  logic [SUB_W-1:0]   sub_lim;
  logic [DATA_W-1:0]  beat_val;
  logic               accept;

  always_comb begin
    span     = (SUB_W+1)'(1) << ratio_q;
    sub_lim  = SUB_W'(span - 1'b1);
    accept   = wr && en && in_cfg && xfer && !busy;
    if (w32_q)     beat_val = word_q;
    else if (hi_q) beat_val = {{HALF_W{1'b0}}, word_q[DATA_W-1:HALF_W]};
    else           beat_val = {{(DATA_W-HALF_W){1'b0}}, word_q[HALF_W-1:0]};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      strobe  <= 1'b0;
      dat     <= '0;
      busy    <= 1'b0;
      err     <= 1'b0;
      word_q  <= '0;
      w32_q   <= 1'b0;
      ratio_q <= '0;
      sub_q   <= '0;
      hi_q    <= 1'b0;
    end else begin
      strobe <= 1'b0;
      dat    <= '0;
      if (wr && (!in_cfg || busy)) err <= 1'b1;
      if (!en || !in_cfg) begin
        busy <= 1'b0;
      end else if (busy) begin
        strobe <= 1'b1;
        dat    <= beat_val;
        if (sub_q == sub_lim) begin
          sub_q <= '0;
          if (w32_q || hi_q) busy <= 1'b0;
          else               hi_q <= 1'b1;
        end else begin
          sub_q <= SUB_W'(sub_q + 1'b1);
        end
      end else if (accept) begin
        busy    <= 1'b1;
        word_q  <= wdata;
        w32_q   <= width32;
        ratio_q <= ratio;
        sub_q   <= '0;
        hi_q    <= 1'b0;
      end
    end
  end

  assert_err_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    err |=> err);
  assert_take_only_when_open_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(xfer && in_cfg && en));
  assert_halt_when_off_R10: assert property (@(posedge clk) disable iff (rst)
    !en |=> !busy);
endmodule

// File: rtl/cfgseq_phase.sv
module cfgseq_phase
  import cfgseq_pkg::*;
#(
  parameter int unsigned FIN_CLKS = 4
) (
  input  logic   clk,
  input  logic   rst,
  input  logic   en,
  input  logic   pull,
  input  logic   done_in,
  input  logic   stat_in,
  input  logic   beat_busy,
  output phase_e phase,
  output logic   xfer_clr,
  output logic   fin_strobe
);
  localparam int unsigned FIN_W = $clog2(FIN_CLKS + 1);

  logic [FIN_W-1:0] fin_cnt;
  logic             good;
  logic             bad;

  always_comb begin
    good     = done_in && stat_in;
    bad      = !done_in && !stat_in;
    xfer_clr = en && (phase == PH_CFG) && !pull && !beat_busy && good;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase      <= PH_PWRUP;
      fin_cnt    <= '0;
      fin_strobe <= 1'b0;
    end else begin
      fin_strobe <= 1'b0;
      if (en) begin
        case (phase)
          PH_PWRUP, PH_USER, PH_UNK: if (pull) phase <= PH_RST;
          PH_RST: if (!pull) phase <= PH_CFG;
          PH_CFG: begin
            if (pull) phase <= PH_RST;
            else if (!beat_busy && good) begin
              phase   <= PH_INIT;
              fin_cnt <= FIN_W'(FIN_CLKS);
            end else if (bad) phase <= PH_UNK;
          end
          PH_INIT: begin
            if (pull) phase <= PH_RST;
            else if (fin_cnt != '0) begin
              fin_strobe <= 1'b1;
              fin_cnt    <= FIN_W'(fin_cnt - 1'b1);
              if (fin_cnt == FIN_W'(1)) phase <= PH_USER;
            end else phase <= PH_USER;
          end
          default: phase <= PH_UNK;
        endcase
      end
    end
  end

  assert_phase_legal_R1: assert property (@(posedge clk) disable iff (rst)
    phase <= PH_UNK);
  assert_frozen_when_off_R10: assert property (@(posedge clk) disable iff (rst)
    (phase != $past(phase)) |-> $past(en));
  assert_user_after_init_R8: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_USER && $past(phase) != PH_USER) |-> $past(phase) == PH_INIT);
  assert_cfg_after_reset_R3: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_CFG && $past(phase) != PH_CFG) |-> $past(phase) == PH_RST);
endmodule

// File: rtl/cfgseq_regs.sv
module cfgseq_regs
  import cfgseq_pkg::*;
#(
  parameter int unsigned ADDR_W  = 4,
  parameter int unsigned MODE_W  = 5,
  parameter int unsigned RATIO_W = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [REG_W-1:0]   wdata,
  input  logic               xfer_clr,
  input  phase_e             phase,
  input  logic [MODE_W-1:0]  mode_pins,
  output logic [REG_W-1:0]   rdata,
  output logic               en,
  output logic               nce,
  output logic               pull,
  output logic               xfer,
  output logic               width32,
  output logic [RATIO_W-1:0] ratio
);
  logic [REG_W-1:0] ctrl;
  logic [REG_W-1:0] status;
  logic             hit_ctrl;

  always_comb begin
    hit_ctrl = (addr == ADDR_W'(OFS_CTRL));
    status   = '0;
    status[PHASE_W-1:0]       = phase;
    status[PHASE_W +: MODE_W] = mode_pins;
    en      = ctrl[CB_EN];
    nce     = ctrl[CB_NCE];
    pull    = ctrl[CB_PULL];
    xfer    = ctrl[CB_XFER];
    width32 = ctrl[CB_WIDTH];
    ratio   = ctrl[CB_RATIO +: RATIO_W];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl  <= CTRL_RESET;
      rdata <= '0;
    end else begin
      if (wr && hit_ctrl) ctrl <= wdata & CTRL_MASK;
      if (xfer_clr) ctrl[CB_XFER] <= 1'b0;
      if (addr == ADDR_W'(OFS_STATUS)) rdata <= status;
      else if (hit_ctrl)               rdata <= ctrl;
      else                             rdata <= '0;
    end
  end

  assert_ctrl_write_R2: assert property (@(posedge clk) disable iff (rst)
    (wr && hit_ctrl && !xfer_clr) |=> ctrl == ($past(wdata) & CTRL_MASK));
endmodule

// File: rtl/cfg_sequencer.sv
module cfg_sequencer
  import cfgseq_pkg::*;
#(
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned ADDR_W   = 4,
  parameter int unsigned MODE_W   = 5,
  parameter int unsigned RATIO_W  = 2,
  parameter int unsigned FIN_CLKS = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              data_wr,
  input  logic [DATA_W-1:0] data_in,
  input  logic [MODE_W-1:0] mode_pins,
  input  logic              done_in,
  input  logic              stat_in,
  output logic              cfg_pull,
  output logic              cfg_ce_n,
  output logic              cfg_strobe,
  output logic [DATA_W-1:0] cfg_data,
  output logic              data_err
);
  phase_e             phase;
  logic               en, nce, pull, xfer, width32;
  logic [RATIO_W-1:0] ratio;
  logic               xfer_clr, fin_strobe;
  logic               beat_strobe, beat_busy;
  logic [DATA_W-1:0]  beat_dat;

  cfgseq_regs #(.ADDR_W(ADDR_W), .MODE_W(MODE_W), .RATIO_W(RATIO_W)) u_regs (
    .clk(clk), .rst(rst), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .xfer_clr(xfer_clr), .phase(phase), .mode_pins(mode_pins), .rdata(reg_rdata),
    .en(en), .nce(nce), .pull(pull), .xfer(xfer), .width32(width32), .ratio(ratio)
  );

  cfgseq_phase #(.FIN_CLKS(FIN_CLKS)) u_phase (
    .clk(clk), .rst(rst), .en(en), .pull(pull), .done_in(done_in),
    .stat_in(stat_in), .beat_busy(beat_busy), .phase(phase),
    .xfer_clr(xfer_clr), .fin_strobe(fin_strobe)
  );

  cfgseq_beat #(.DATA_W(DATA_W), .RATIO_W(RATIO_W)) u_beat (
    .clk(clk), .rst(rst), .en(en), .in_cfg(phase == PH_CFG), .xfer(xfer),
    .wr(data_wr), .wdata(data_in), .width32(width32), .ratio(ratio),
    .strobe(beat_strobe), .dat(beat_dat), .busy(beat_busy), .err(data_err)
  );

  assign cfg_pull   = en && pull;
  assign cfg_ce_n   = nce;
  assign cfg_strobe = beat_strobe | fin_strobe;
  assign cfg_data   = beat_dat;

  assert_no_overlap_R8: assert property (@(posedge clk) disable iff (rst)
    !(beat_strobe && fin_strobe));
  assert_xfer_dropped_R8: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_INIT && $past(phase) == PH_CFG) |-> !xfer);
  assert_strobe_source_R4: assert property (@(posedge clk) disable iff (rst)
    beat_strobe |-> $past(phase == PH_CFG));
endmodule

// File: tb/cfg_sequencer_test.sv
module cfg_sequencer_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        data_wr = 1'b0;
  logic [31:0] data_in = '0;
  logic [4:0]  mode_pins = 5'b10110;
  logic        done_in = 1'b0;
  logic        stat_in = 1'b1;
  logic        cfg_pull, cfg_ce_n, cfg_strobe, data_err;
  logic [31:0] cfg_data;
  int          n_chk = 0;
  int          n_bad = 0;

  always #5 clk = ~clk;

  cfg_sequencer uut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .data_wr(data_wr),
    .data_in(data_in), .mode_pins(mode_pins), .done_in(done_in),
    .stat_in(stat_in), .cfg_pull(cfg_pull), .cfg_ce_n(cfg_ce_n),
    .cfg_strobe(cfg_strobe), .cfg_data(cfg_data), .data_err(data_err)
  );

  // width bit, ratio, word
  localparam logic [34:0] VECS [6] = '{
    {1'b1, 2'd0, 32'hA5A5_0001},
    {1'b1, 2'd2, 32'h1234_5678},
    {1'b0, 2'd0, 32'hBEEF_CAFE},
    {1'b0, 2'd1, 32'h0F0F_F0F0},
    {1'b0, 2'd3, 32'hDEAD_0042},
    {1'b1, 2'd3, 32'h8000_0001}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_reg(input logic [3:0] a, input logic [31:0] v);
    reg_addr = a; reg_wdata = v; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [3:0] a, output logic [31:0] v);
    reg_addr = a;
    @(negedge clk);
    v = reg_rdata;
  endtask

  task automatic send_word(input logic [31:0] w);
    data_in = w; data_wr = 1'b1;
    @(negedge clk);
    data_wr = 1'b0;
  endtask

  function automatic logic [31:0] beat_exp(input logic w32, input logic hi, input logic [31:0] w);
    if (w32) return w;
    return hi ? {16'h0, w[31:16]} : {16'h0, w[15:0]};
  endfunction

  task automatic expect_stream(input string req, input logic w32, input logic [1:0] r,
                               input logic [31:0] w);
    int n = 1 << r;
    int total = w32 ? n : 2 * n;
    for (int k = 0; k < total; k++) begin
      tick(1);
      check({req, " strobe"}, {31'h0, cfg_strobe}, 32'h1);
      check({req, " data"}, cfg_data, beat_exp(w32, (k >= n), w));
    end
    tick(1);
    check({req, " end"}, {31'h0, cfg_strobe}, 32'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int seen;
    tick(3);
    rst = 1'b0;
    // R1 reset state
    check("R1 strobe", {31'h0, cfg_strobe}, 32'h0);
    check("R1 err", {31'h0, data_err}, 32'h0);
    check("R1 pull", {31'h0, cfg_pull}, 32'h0);
    check("R1 ce_n", {31'h0, cfg_ce_n}, 32'h1);
    rd_reg(4'h0, v); check("R1 status", v, 32'hB0);
    rd_reg(4'h4, v); check("R1 ctrl", v, 32'h2);
    // R2 mask, pull without enable leaves phase (R10)
    wr_reg(4'h4, 32'hFFFF_FFFE);
    rd_reg(4'h4, v); check("R2 ctrl mask", v, 32'h3C6);
    tick(1);
    rd_reg(4'h0, v); check("R10 no enable", v, 32'hB0);
    // R3 bring-up
    wr_reg(4'h4, 32'h5);
    check("R3 pull out", {31'h0, cfg_pull}, 32'h1);
    check("R2 ce_n", {31'h0, cfg_ce_n}, 32'h0);
    tick(2);
    rd_reg(4'h0, v); check("R3 reset phase", v, 32'hB1);
    wr_reg(4'h4, 32'h1);
    tick(2);
    rd_reg(4'h0, v); check("R3 cfg phase", v, 32'hB2);
    check("R3 pull off", {31'h0, cfg_pull}, 32'h0);
    // R4 transfer enable clear: write ignored
    send_word(32'h7777_7777);
    seen = 0;
    for (int k = 0; k < 10; k++) begin tick(1); if (cfg_strobe) seen++; end
    check("R4 no strobes", seen, 0);
    check("R4 no err", {31'h0, data_err}, 32'h0);
    // R5 / R6 vector walk
    for (int i = 0; i < 6; i++) begin
      logic        w32 = VECS[i][34];
      logic [1:0]  r   = VECS[i][33:32];
      logic [31:0] w   = VECS[i][31:0];
      wr_reg(4'h4, 32'h101 | (32'(w32) << 9) | (32'(r) << 6));
      send_word(w);
      expect_stream(w32 ? "R5" : "R6", w32, r, w);
    end
    // R7 write while busy
    wr_reg(4'h4, 32'h301);
    data_in = 32'h1111_2222; data_wr = 1'b1;
    tick(1);
    data_in = 32'h3333_4444;
    tick(1);
    data_wr = 1'b0;
    check("R7 first beat", cfg_data, 32'h1111_2222);
    check("R7 busy err", {31'h0, data_err}, 32'h1);
    tick(1);
    check("R7 dropped", {31'h0, cfg_strobe}, 32'h0);
    // R8 completion
    done_in = 1'b1; stat_in = 1'b1;
    tick(1);
    for (int k = 0; k < 4; k++) begin
      tick(1);
      check("R8 fin strobe", {31'h0, cfg_strobe}, 32'h1);
      check("R8 fin data", cfg_data, 32'h0);
    end
    tick(1);
    check("R8 fin end", {31'h0, cfg_strobe}, 32'h0);
    rd_reg(4'h0, v); check("R8 user", v, 32'hB4);
    rd_reg(4'h4, v); check("R8 xfer clr", v, 32'h201);

    // second run
    rst = 1'b1; done_in = 1'b0; stat_in = 1'b1;
    tick(2);
    rst = 1'b0;
    check("R1 err cleared", {31'h0, data_err}, 32'h0);
    send_word(32'h5555_5555);
    check("R7 outside cfg", {31'h0, data_err}, 32'h1);
    tick(1);
    check("R7 no strobe", {31'h0, cfg_strobe}, 32'h0);
    wr_reg(4'h4, 32'h5); tick(2);
    wr_reg(4'h4, 32'h1); tick(2);
    rd_reg(4'h0, v); check("R3 cfg again", v, 32'hB2);
    // R10 enable cleared mid-word
    wr_reg(4'h4, 32'h1C1);
    send_word(32'hCAFE_F00D);
    tick(3);
    wr_reg(4'h4, 32'h1C0);
    tick(1);
    seen = 0;
    for (int k = 0; k < 20; k++) begin tick(1); if (cfg_strobe) seen++; end
    check("R10 stream halted", seen, 0);
    rd_reg(4'h0, v); check("R10 phase kept", v, 32'hB2);
    wr_reg(4'h4, 32'h4); tick(2);
    rd_reg(4'h0, v); check("R10 pull ignored", v, 32'hB2);
    check("R10 pull out", {31'h0, cfg_pull}, 32'h0);
    wr_reg(4'h4, 32'h0);
    done_in = 1'b0; stat_in = 1'b0;
    tick(2);
    rd_reg(4'h0, v); check("R10 fail ignored", v, 32'hB2);
    // R9 failure
    wr_reg(4'h4, 32'h1); tick(2);
    rd_reg(4'h0, v); check("R9 unknown", v, 32'hB5);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule